// File: doc/BRIEF.md
# Dual-Mode Tuneword Receiver

This block receives an 8-bit tuning word for a tunable device and passes it on with a tune-start strobe. The word can arrive in either of two ways. The first is a three-wire serial link made of a serial clock, a load strobe and a data line, where the data line is the same pin as bus bit 0. The second is a parallel bus that is captured by the load strobe. The mode is read from a select pin once after reset. After that, changes on the select pin have no effect.

Every pin is brought into the fast system clock through two-stage synchronizers. Edges are found by comparing each synchronized sample with the one before it. A completed load updates the stored word and raises `tune_start_o` for one clock.

A switch-enable input controls the power-converter enable output. While the converter is off, the block still accepts words but holds back the tune strobe. When the converter comes back on, the block issues a tune strobe for the last stored word without that word being sent again.

There is no back-pressure on the output side. `word_o` holds its value until the next completed load, and `tune_start_o` acts as a valid strobe that the consumer must accept in the cycle it is high.

Top module: `tuneword_rx`

## Requirements
- R1: After reset, `word_o` is 0x00, `tune_start_o` is low and `conv_en_o` is high.
- R2: The interface mode is taken from `if_sel_i` once, shortly after reset. A 0 selects serial mode and a 1 selects parallel mode. Later changes on `if_sel_i` have no effect until the next reset.
- R3: In serial mode, a rising edge on `load_i` opens a frame. Each rising edge of `sclk_i` inside the frame shifts in `tune_bus_i[0]`, most significant bit first. The falling edge of `load_i` closes the frame, stores the word and pulses `tune_start_o`.
- R4: In serial mode, rising edges of `sclk_i` while `load_i` is low do not add bits to any frame.
- R5: In serial mode, if a frame carries more than 8 bits, the word stored is the last 8 bits received.
- R6: In serial mode, a frame that closes with fewer than 8 bits is discarded. `word_o` is unchanged and no tune strobe is issued.
- R7: In parallel mode, the falling edge of `load_i` captures `tune_bus_i[7:0]` (bit 7 is the MSB) and pulses `tune_start_o`. The rising edge of `load_i` and any activity on `sclk_i` have no effect.
- R8: `tune_start_o` is a single-cycle pulse. It never asserts before the first completed load.
- R9: While `sw_en_i` is low, `conv_en_o` is low and the stored word is retained. Words loaded during this time are stored, but their tune strobe is withheld.
- R10: When `sw_en_i` returns high, `conv_en_o` goes high. One tune strobe is issued for the last stored word, but only if some word has been stored since reset.
- R11: A `load_i` falling edge that completes a load raises `tune_start_o` in the third clock after the pin changes: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_sel_i | input | 1 | Interface select, sampled once after reset (0 serial, 1 parallel) |
| tune_bus_i | input | 8 | Parallel word; bit 0 doubles as serial data |
| load_i | input | 1 | Load strobe (frame in serial mode, capture in parallel mode) |
| sclk_i | input | 1 | Serial bit clock, rising edge active |
| sw_en_i | input | 1 | Switch enable; low turns the converter off |
| word_o | output | 8 | Last stored tuning word |
| tune_start_o | output | 1 | One-cycle tune request |
| conv_en_o | output | 1 | Power-converter enable |

## Verification
The bench sends serial frames with exactly eight bits, with more than eight, and with fewer than eight. A design that drops the oldest bits in the wrong order, or that commits a short frame, shows a wrong word or an extra strobe. It also sends clock pulses before a frame opens and toggles the select pin after reset. A design that counts idle clocks, or that keeps sampling the mode pin, then commits words it should discard. The bench also covers the power-down path. A block that loses the word while the converter is off, strobes during power-down, retunes with no word ever stored, or strobes late or for more than one cycle shows up in the pulse counts and the cycle-exact latency check.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic {
    IF_SERIAL   = 1'b0,
    IF_PARALLEL = 1'b1
  } if_mode_e;
endpackage

// File: rtl/tw_sync.sv
// Multi-stage level synchronizer; one chain per bit.
module tw_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tw_edge_det.sv
// Rise/fall detection against the previous synchronized sample.
module tw_edge_det #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/tw_serial_rx.sv
// Serial frame assembler: MSB-first shift, bit count saturating at WORD_W.
module tw_serial_rx #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              load_lvl_i,
  input  logic              load_rise_i,
  input  logic              load_fall_i,
  input  logic              sclk_rise_i,
  input  logic              din_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
    end else if (load_rise_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      shift_q  <= '0;
    end else if (load_fall_i) begin
      active_q <= 1'b0;
    end else if (sclk_rise_i && active_q && load_lvl_i) begin
      shift_q <= {shift_q[WORD_W-2:0], din_i};
      if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign commit_o = en_i & load_fall_i & active_q & (cnt_q == CNT_W'(WORD_W));
  assign word_o   = shift_q;

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));

  p_idle_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_lvl_i |=> $stable(shift_q));
endmodule

// File: rtl/tw_power_ctl.sv
// Converter enable follows switch-enable once the block is settled;
// a re-enable produces a one-cycle retune request.
module tw_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic locked_i,
  input  logic sw_lvl_i,
  output logic conv_en_o,
  output logic reen_o
);
  logic conv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        conv_q <= 1'b1;
    else if (locked_i) conv_q <= sw_lvl_i;
  end

  assign conv_en_o = conv_q;
  assign reen_o    = locked_i & sw_lvl_i & ~conv_q;

  p_conv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_i && !sw_lvl_i |=> !conv_en_o);

  p_reen_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reen_o |=> conv_en_o);
endmodule

// File: rtl/tuneword_rx.sv
module tuneword_rx #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_sel_i,
  input  logic [WORD_W-1:0] tune_bus_i,
  input  logic              load_i,
  input  logic              sclk_i,
  input  logic              sw_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tune_start_o,
  output logic              conv_en_o
);
  import tw_pkg::*;

  localparam int unsigned IN_W   = WORD_W + 4;
  localparam int unsigned IX_LD  = WORD_W;
  localparam int unsigned IX_SCK = WORD_W + 1;
  localparam int unsigned IX_SW  = WORD_W + 2;
  localparam int unsigned IX_SEL = WORD_W + 3;
  localparam int unsigned SET_W  = $clog2(SYNC_STAGES + 1);
  localparam logic [IN_W-1:0] SYNC_RST = IN_W'(1) << IX_SW;

  logic [IN_W-1:0] raw, syn;
  logic [1:0]      edge_rise, edge_fall;
  logic            unused_sclk_fall;

  assign raw = {if_sel_i, sw_en_i, sclk_i, load_i, tune_bus_i};

  tw_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  tw_edge_det #(.W(2), .RST_VAL(2'b00)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(syn[IX_SCK:IX_LD]),
    .rise_o(edge_rise), .fall_o(edge_fall));

  assign unused_sclk_fall = edge_fall[1];

  // Mode lock once the synchronizer has filled
  logic [SET_W-1:0] settle_q;
  logic             locked_q;
  if_mode_e         mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      locked_q <= 1'b0;
      mode_q   <= IF_SERIAL;
    end else if (!locked_q) begin
      if (settle_q == SET_W'(SYNC_STAGES)) begin
        locked_q <= 1'b1;
        mode_q   <= if_mode_e'(syn[IX_SEL]);
      end else begin
        settle_q <= settle_q + 1'b1;
      end
    end
  end

  logic              ser_en, ser_commit, par_commit, store_en;
  logic [WORD_W-1:0] ser_word, store_val;

  assign ser_en = locked_q & (mode_q == IF_SERIAL);

  tw_serial_rx #(.WORD_W(WORD_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .en_i(ser_en),
    .load_lvl_i(syn[IX_LD]), .load_rise_i(edge_rise[0]), .load_fall_i(edge_fall[0]),
    .sclk_rise_i(edge_rise[1]), .din_i(syn[0]),
    .commit_o(ser_commit), .word_o(ser_word));

  assign par_commit = locked_q & (mode_q == IF_PARALLEL) & edge_fall[0];
  assign store_en   = ser_commit | par_commit;
  assign store_val  = par_commit ? syn[WORD_W-1:0] : ser_word;

  logic conv_en, reen;

  tw_power_ctl u_power (
    .clk(clk), .rst_n(rst_n), .locked_i(locked_q), .sw_lvl_i(syn[IX_SW]),
    .conv_en_o(conv_en), .reen_o(reen));

  logic [WORD_W-1:0] word_q;
  logic              have_word_q, tune_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      have_word_q <= 1'b0;
      tune_q      <= 1'b0;
    end else begin
      if (store_en) begin
        word_q      <= store_val;
        have_word_q <= 1'b1;
      end
      tune_q <= (store_en & conv_en) | (reen & (have_word_q | store_en));
    end
  end

  assign word_o       = word_q;
  assign tune_start_o = tune_q;
  assign conv_en_o    = conv_en;

  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && $past(locked_q) |-> $stable(mode_q));

  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(store_en) |-> $stable(word_q));

  p_no_early_tune_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !have_word_q |-> !tune_start_o);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en && !syn[IX_SW] |=> !tune_start_o);
endmodule

// File: tb/tuneword_rx_bench.sv
`timescale 1ns/1ps
module tuneword_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       if_sel = 1'b0;
  logic [7:0] bus = '0;
  logic       load = 1'b0;
  logic       sclk = 1'b0;
  logic       sw_en = 1'b1;
  logic [7:0] word_o;
  logic       tune_start_o, conv_en_o;

  always #2.5 clk = ~clk;

  tuneword_rx u_tuneword_rx (
    .clk(clk), .rst_n(rst_n), .if_sel_i(if_sel), .tune_bus_i(bus),
    .load_i(load), .sclk_i(sclk), .sw_en_i(sw_en),
    .word_o(word_o), .tune_start_o(tune_start_o), .conv_en_o(conv_en_o));

  int nchk = 0, nfail = 0, pulses = 0, doubles = 0;
  bit last_tune = 1'b0, done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tune_start_o) pulses++;
      if (tune_start_o && last_tune) doubles++;
      last_tune = tune_start_o;
    end else begin
      last_tune = 1'b0;
    end
  end

  // {nbits[3:0], bits[15:0], 3'b0, commit, expected word[7:0]}
  localparam logic [31:0] SER_VEC [8] = '{
    32'h800A51A5, 32'h8003C13C, 32'h800FF1FF, 32'h80000100,
    32'hA0281181, 32'hC0F5A15A, 32'h5001305A, 32'h80096196 };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit sel);
    rst_n = 1'b0; if_sel = sel; load = 1'b0; sclk = sel; sw_en = 1'b1; bus = '0;
    tick(3);
    rst_n = 1'b1;
    tick(8);
  endtask

  task automatic send_bits(int nbits, logic [15:0] bits);
    for (int i = nbits - 1; i >= 0; i--) begin
      bus[0] = bits[i]; tick(4);
      sclk = 1'b1; tick(4);
      sclk = 1'b0;
    end
    tick(4);
  endtask

  task automatic send_serial(int nbits, logic [15:0] bits);
    load = 1'b1; tick(4);
    send_bits(nbits, bits);
    load = 1'b0; tick(8);
  endtask

  task automatic par_load(logic [7:0] d);
    bus = d; tick(4);
    load = 1'b1; tick(4);
    load = 1'b0; tick(8);
  endtask

  initial begin
    int p0;
    do_reset(1'b0);
    // R1 reset state
    check(word_o == 8'h00, "R1", "word", word_o, 0);
    check(conv_en_o == 1'b1, "R1", "conv_en", conv_en_o, 1);
    check(pulses == 0, "R1", "pulses", pulses, 0);
    // R10: re-enable with nothing stored issues no tune
    sw_en = 1'b0; tick(8);
    check(conv_en_o == 1'b0, "R9", "conv_en off", conv_en_o, 0);
    sw_en = 1'b1; tick(8);
    check(conv_en_o == 1'b1, "R10", "conv_en on", conv_en_o, 1);
    check(pulses == 0, "R8", "no tune before first load", pulses, 0);

    // Serial vector table: R3 exact frames, R5 long, R6 short
    foreach (SER_VEC[k]) begin
      logic [31:0] v;
      string tag;
      v = SER_VEC[k];
      tag = (v[31:28] > 4'd8) ? "R5" : (v[31:28] < 4'd8) ? "R6" : "R3";
      p0 = pulses;
      send_serial(int'(v[31:28]), v[27:12]);
      check(word_o == v[7:0], tag, "serial word", word_o, v[7:0]);
      check(pulses == p0 + int'(v[8]), tag, "serial pulses", pulses - p0, v[8]);
    end
    check(doubles == 0, "R8", "pulse width", doubles, 0);

    // R4: idle clocks before a short frame must not count
    p0 = pulses;
    bus[0] = 1'b1;
    for (int j = 0; j < 3; j++) begin
      sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    send_serial(5, 16'h0000);
    check(word_o == 8'h96, "R4", "word after idle clocks", word_o, 8'h96);
    check(pulses == p0, "R4", "pulses after idle clocks", pulses - p0, 0);

    // R11: strobe exactly three clocks after load falls
    load = 1'b1; tick(4);
    send_bits(8, 16'h00C3);
    load = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(tune_start_o == 1'b0, "R11", "tune after 2 edges", tune_start_o, 0);
    @(posedge clk); @(negedge clk);
    check(tune_start_o == 1'b1, "R11", "tune after 3 edges", tune_start_o, 1);
    check(word_o == 8'hC3, "R11", "word", word_o, 8'hC3);
    tick(8);

    // R9 / R10: power-down keeps word, withholds strobe, retunes on return
    sw_en = 1'b0; tick(8);
    check(conv_en_o == 1'b0, "R9", "conv_en off", conv_en_o, 0);
    check(word_o == 8'hC3, "R9", "word retained", word_o, 8'hC3);
    p0 = pulses;
    send_serial(8, 16'h0042);
    check(word_o == 8'h42, "R9", "word stored while off", word_o, 8'h42);
    check(pulses == p0, "R9", "strobe withheld", pulses - p0, 0);
    sw_en = 1'b1; tick(8);
    check(conv_en_o == 1'b1, "R10", "conv_en on", conv_en_o, 1);
    check(pulses == p0 + 1, "R10", "retune strobe", pulses - p0, 1);
    check(word_o == 8'h42, "R10", "retune word", word_o, 8'h42);

    // R2: select pin changes after reset are ignored
    if_sel = 1'b1; tick(8);
    p0 = pulses;
    par_load(8'h11);
    check(word_o == 8'h42, "R2", "serial mode kept", word_o, 8'h42);
    check(pulses == p0, "R2", "no parallel capture", pulses - p0, 0);

    // Parallel mode
    do_reset(1'b1);
    check(word_o == 8'h00, "R1", "word after reset", word_o, 0);
    if_sel = 1'b0; tick(8);
    begin
      logic [7:0] pv [4] = '{8'h12, 8'hEF, 8'h80, 8'h01};
      foreach (pv[k]) begin
        p0 = pulses;
        par_load(pv[k]);
        check(word_o == pv[k], "R7", "parallel word", word_o, pv[k]);
        check(pulses == p0 + 1, "R7", "parallel strobe", pulses - p0, 1);
      end
    end
    // R7: rising load and sclk activity do nothing; capture at the fall
    p0 = pulses;
    bus = 8'h77; tick(4);
    load = 1'b1; tick(8);
    sclk = 1'b0; tick(4); sclk = 1'b1; tick(8);
    check(word_o == 8'h01, "R7", "no capture on rise", word_o, 8'h01);
    check(pulses == p0, "R7", "no strobe on rise", pulses - p0, 0);
    bus = 8'h3C; tick(6);
    load = 1'b0; tick(8);
    check(word_o == 8'h3C, "R7", "capture at fall", word_o, 8'h3C);
    check(pulses == p0 + 1, "R7", "strobe at fall", pulses - p0, 1);
    check(doubles == 0, "R8", "pulse width", doubles, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule